// File: doc/BRIEF.md
# ECC Error Report Aggregator

This block gathers the per-packet results of a BCH decoder while one flash page streams through it, and condenses them into a single 32-bit report word plus a transfer status word carrying a page-empty flag. Each decoded packet arrives as a one-cycle strobe. The strobe carries the packet's corrected-bit count, a decode-success flag, a marker for the page's first packet, and a marker for its last packet.

The first packet is reported on its own in the low byte of the report. Every later packet is merged into the second byte. That byte holds the largest count seen among those packets and a success bit that stays set only while every one of them decoded. An erased-page indication from the read path sets a sticky empty flag. A page-start pulse returns everything to its idle state. The results stay on the outputs until the next page starts, and a valid flag tells the reader when the last packet has been folded in.

Top module: `ecc_report_agg`

## Requirements
- R1: After reset, report_word is 0x0000_8080 (both counts zero, both success bits set), status_word is zero, and report_valid is low.
- R2: A page_start pulse with no packet strobe in the same cycle makes the next cycle show both counts at zero, bits 7 and 15 set, status_word zero and report_valid low.
- R3: A strobe with pkt_first high loads report bits 5:0 with that packet's count and bit 7 with its success flag. The value is visible in the cycle after the strobe.
- R4: Strobes with pkt_first low set report bits 13:8 to the maximum of their counts since page_start, not the sum.
- R5: Report bit 15 is the AND of the success flags of all non-first packets since page_start. A first-packet strobe leaves bits 15:8 unchanged, and a later-packet strobe leaves bits 7:0 unchanged.
- R6: A count of 63 or more is reported as 63 in both count fields.
- R7: page_erased sets status_word bit 16, which stays set until the next page_start. All other status_word bits are always zero.
- R8: report_valid rises in the cycle after a strobe with pkt_last high, and stays high until the next page_start.
- R9: A packet strobe or page_erased arriving in the same cycle as page_start belongs to the new page. Counting starts from the cleared state and includes that packet. A same-cycle pkt_last leaves report_valid high.
- R10: Report bits 6, 14 and 31:16 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_start | input | 1 | One-cycle pulse that opens a new page |
| pkt_valid | input | 1 | Packet result strobe |
| pkt_first | input | 1 | Strobed packet is the first of the page |
| pkt_last | input | 1 | Strobed packet is the last of the page |
| pkt_ok | input | 1 | Strobed packet decoded successfully |
| pkt_errs | input | CNT_IN_W | Corrected-bit count of the strobed packet |
| page_erased | input | 1 | Read path found the page erased |
| report_word | output | 32 | Packed error report |
| status_word | output | 32 | Transfer status, bit 16 = page empty |
| report_valid | output | 1 | All packets of the page have been folded in |

## Verification
The clear of a new page and the merge of a packet can fall in the same clock. The bench provokes this by raising page_start together with a first-packet strobe, then together with a last later-packet strobe, and then together with page_erased. Each time it expects the report to show that packet's own fields over the cleared defaults of the other byte, with no trace of the previous page's larger counts or failure bits. The same collision is watched for report_valid, which must be low after a non-last packet and high after a last packet.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
   localparam int RPT_CNT_W   = 6;
   localparam int RPT_CNT_MAX = (1 << RPT_CNT_W) - 1;
   localparam int EMPTY_BIT   = 16;

   // byte 0: first packet, byte 1: remaining packets; success bits at 7 and 15
   function automatic logic [31:0] pack_report(input logic [RPT_CNT_W-1:0] c_first,
                                               input logic                 ok_first,
                                               input logic [RPT_CNT_W-1:0] c_rest,
                                               input logic                 ok_rest);
      return {16'h0000, ok_rest, 1'b0, c_rest, ok_first, 1'b0, c_first};
   endfunction
endpackage

// File: rtl/ecc_cnt_clamp.sv
module ecc_cnt_clamp #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 6
) (
   input  logic [IN_W-1:0]  cnt_in,
   output logic [OUT_W-1:0] cnt_out
);
   generate
      if (IN_W < 1 || OUT_W < 1) begin : g_bad_width
         $error("ecc_cnt_clamp: widths must be positive");
      end
      if (IN_W > OUT_W) begin : g_saturate
         always_comb begin
            if (|cnt_in[IN_W-1:OUT_W]) cnt_out = '1;
            else                       cnt_out = cnt_in[OUT_W-1:0];
         end
      end else begin : g_extend
         always_comb cnt_out = OUT_W'(cnt_in);
      end
   endgenerate
endmodule

// File: rtl/ecc_grp_acc.sv
module ecc_grp_acc #(
   parameter int CW      = 6,
   parameter bit USE_MAX = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          upd,
   input  logic [CW-1:0] cnt_in,
   input  logic          ok_in,
   output logic [CW-1:0] cnt_q,
   output logic          ok_q
);
   logic [CW-1:0] base_cnt, merged_cnt;
   logic          base_ok, merged_ok;

   // a same-cycle clear starts the group fresh before the update merges in
   always_comb begin
      base_cnt = clr ? '0   : cnt_q;
      base_ok  = clr ? 1'b1 : ok_q;
   end

   generate
      if (CW < 1) begin : g_bad_width
         $error("ecc_grp_acc: CW must be positive");
      end
      if (USE_MAX) begin : g_max
         always_comb begin
            merged_cnt = (cnt_in > base_cnt) ? cnt_in : base_cnt;
            merged_ok  = base_ok & ok_in;
         end

         p_no_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> cnt_q >= $past(cnt_q));
      end else begin : g_load
         always_comb begin
            merged_cnt = cnt_in;
            merged_ok  = ok_in;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ok_q  <= 1'b1;
      end else if (upd) begin
         cnt_q <= merged_cnt;
         ok_q  <= merged_ok;
      end else begin
         cnt_q <= base_cnt;
         ok_q  <= base_ok;
      end
   end
endmodule

// File: rtl/ecc_report_agg.sv
module ecc_report_agg
   import ecc_rpt_pkg::*;
#(
   parameter int CNT_IN_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                page_start,
   input  logic                pkt_valid,
   input  logic                pkt_first,
   input  logic                pkt_last,
   input  logic                pkt_ok,
   input  logic [CNT_IN_W-1:0] pkt_errs,
   input  logic                page_erased,
   output logic [31:0]         report_word,
   output logic [31:0]         status_word,
   output logic                report_valid
);
   generate
      if (CNT_IN_W < 1 || CNT_IN_W > 16) begin : g_bad_param
         $error("ecc_report_agg: CNT_IN_W out of range");
      end
   endgenerate

   logic [RPT_CNT_W-1:0] errs_sat;
   logic [RPT_CNT_W-1:0] c_first, c_rest;
   logic                 ok_first, ok_rest;
   logic                 empty_q, valid_q;
   logic                 upd_first, upd_rest;

   assign upd_first = pkt_valid &  pkt_first;
   assign upd_rest  = pkt_valid & ~pkt_first;

   ecc_cnt_clamp #(.IN_W(CNT_IN_W), .OUT_W(RPT_CNT_W)) u_clamp (
      .cnt_in (pkt_errs),
      .cnt_out(errs_sat)
   );

   ecc_grp_acc #(.CW(RPT_CNT_W), .USE_MAX(1'b0)) u_grp_first (
      .clk(clk), .rst_n(rst_n), .clr(page_start), .upd(upd_first),
      .cnt_in(errs_sat), .ok_in(pkt_ok), .cnt_q(c_first), .ok_q(ok_first)
   );

   ecc_grp_acc #(.CW(RPT_CNT_W), .USE_MAX(1'b1)) u_grp_rest (
      .clk(clk), .rst_n(rst_n), .clr(page_start), .upd(upd_rest),
      .cnt_in(errs_sat), .ok_in(pkt_ok), .cnt_q(c_rest), .ok_q(ok_rest)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         if (page_erased)     empty_q <= 1'b1;
         else if (page_start) empty_q <= 1'b0;
         if (pkt_valid && pkt_last) valid_q <= 1'b1;
         else if (page_start)       valid_q <= 1'b0;
      end
   end

   assign report_word  = pack_report(c_first, ok_first, c_rest, ok_rest);
   assign status_word  = 32'(empty_q) << EMPTY_BIT;
   assign report_valid = valid_q;

   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (page_start && !pkt_valid && !page_erased) |=>
         (report_word == 32'h0000_8080) && !report_valid && (status_word == 32'h0));

   p_first_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_first && (pkt_errs < CNT_IN_W'(RPT_CNT_MAX))) |=>
         (report_word[5:0] == RPT_CNT_W'($past(pkt_errs))) && (report_word[7] == $past(pkt_ok)));

   p_fail_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_rest && !pkt_ok) |=> !report_word[15]);

   p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_first && (pkt_errs >= CNT_IN_W'(RPT_CNT_MAX))) |=> (report_word[5:0] == 6'd63));

   p_empty_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      page_erased |=> status_word[EMPTY_BIT]);

   p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_last) |=> report_valid);

   p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (report_valid && !page_start) |=> report_valid);
endmodule

// File: tb/ecc_report_agg_test.sv
module ecc_report_agg_test;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          page_start = 1'b0, pkt_valid = 1'b0, pkt_first = 1'b0;
   logic          pkt_last = 1'b0, pkt_ok = 1'b0, page_erased = 1'b0;
   logic [CW-1:0] pkt_errs = '0;
   logic [31:0]   report_word, status_word;
   logic          report_valid;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_report_agg #(.CNT_IN_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .page_start(page_start), .pkt_valid(pkt_valid),
      .pkt_first(pkt_first), .pkt_last(pkt_last), .pkt_ok(pkt_ok), .pkt_errs(pkt_errs),
      .page_erased(page_erased), .report_word(report_word), .status_word(status_word),
      .report_valid(report_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // drive one cycle after a falling edge; outputs are checked at the next falling edge
   task automatic cyc(input logic ps, input logic pv, input logic pf, input logic pl,
                      input logic pk, input int e, input logic er);
      page_start = ps; pkt_valid = pv; pkt_first = pf; pkt_last = pl;
      pkt_ok = pk; pkt_errs = CW'(e); page_erased = er;
      @(negedge clk);
      page_start = 0; pkt_valid = 0; pkt_first = 0; pkt_last = 0;
      pkt_ok = 0; pkt_errs = '0; page_erased = 0;
   endtask

   function automatic logic [31:0] rpt(input int c0, input logic k0, input int cn, input logic kn);
      int s0, sn;
      s0 = (c0 > 63) ? 63 : c0;
      sn = (cn > 63) ? 63 : cn;
      return (32'(kn) << 15) | (32'(sn) << 8) | (32'(k0) << 7) | 32'(s0);
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      chk("R1 report", report_word, 32'h0000_8080);
      chk("R1 status", status_word, 32'h0);
      chk("R1 valid", 32'(report_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3, R6, R8, R10: sweep first-packet counts across and past saturation
      for (int v = 0; v < 72; v++) begin
         cyc(1, 0, 0, 0, 0, 0, 0);
         cyc(0, 1, 1, 1, v[0], v, 0);
         chk("R3 R6 R10 first packet", report_word, rpt(v, v[0], 0, 1'b1));
         chk("R8 valid after last", 32'(report_valid), 32'h1);
      end
      cyc(1, 0, 0, 0, 0, 0, 0);
      cyc(0, 1, 1, 1, 1, 255, 0);
      chk("R6 max input", report_word, rpt(63, 1'b1, 0, 1'b1));

      // R4, R5, R8: pages of 1..6 later packets with arithmetic counts
      for (int n = 1; n <= 6; n++) begin
         for (int s = 0; s < 8; s++) begin
            int mx;
            logic all_ok;
            mx = 0; all_ok = 1'b1;
            cyc(1, 0, 0, 0, 0, 0, 0);
            chk("R2 cleared", report_word, 32'h0000_8080);
            cyc(0, 1, 1, 0, 1, 5, 0);
            chk("R8 not valid before last", 32'(report_valid), 32'h0);
            for (int k = 0; k < n; k++) begin
               int e;
               logic ok;
               e  = (s * 37 + k * 23) % 90;
               ok = ((s + k) % 5) != 3;
               if (e > mx) mx = e;
               all_ok = all_ok & ok;
               cyc(0, 1, 0, (k == n - 1), ok, e, 0);
               chk("R4 R5 later packets", report_word, rpt(5, 1'b1, mx, all_ok));
            end
            chk("R8 valid", 32'(report_valid), 32'h1);
            cyc(0, 0, 0, 0, 0, 0, 0);
            chk("R8 held", 32'(report_valid), 32'h1);
         end
      end

      // R5: first packet must not touch byte 1
      cyc(1, 0, 0, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0, 40, 0);
      cyc(0, 1, 1, 1, 1, 2, 0);
      chk("R5 byte1 untouched", report_word, rpt(2, 1'b1, 40, 1'b0));

      // R9: clear and packet in the same cycle
      cyc(1, 1, 1, 0, 0, 9, 0);
      chk("R9 start+first", report_word, rpt(9, 1'b0, 0, 1'b1));
      chk("R9 valid low", 32'(report_valid), 32'h0);
      cyc(0, 1, 0, 1, 0, 50, 0);
      cyc(1, 1, 0, 1, 0, 12, 0);
      chk("R9 start+rest", report_word, rpt(0, 1'b1, 12, 1'b0));
      chk("R9 valid high", 32'(report_valid), 32'h1);
      cyc(0, 0, 0, 0, 0, 0, 1);
      cyc(1, 0, 0, 0, 0, 0, 1);
      chk("R9 start+erased", status_word, 32'h0001_0000);

      // R7: sticky empty flag
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R7 cleared", status_word, 32'h0);
      cyc(0, 0, 0, 0, 0, 0, 1);
      chk("R7 set", status_word, 32'h0001_0000);
      cyc(0, 1, 1, 1, 1, 3, 0);
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk("R7 held", status_word, 32'h0001_0000);
      cyc(1, 0, 0, 0, 0, 0, 0);
      chk("R7 cleared by start", status_word, 32'h0);
      chk("R2 report idle", report_word, 32'h0000_8080);
      chk("R2 valid low", 32'(report_valid), 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule